// File: doc/BRIEF.md
# Unlockable Banked Indirect Register Port

This block is a management-side register slave with a 32-entry, 16-bit register map. Three of its entries form a window onto a set of hidden register banks, and the rest of the map reads as zero. The banks are reached through a test-control register that stays locked until software writes an exact unlock pattern to it. Once the block is unlocked, one control word selects a bank, a direction and a 5-bit address. A read command moves the selected hidden word into a read-data register. A write command commits a value that was placed in a staging register beforehand.

Software normally brackets each hidden access. It first writes the unlock pattern, then issues the command (after loading the staging register for a write), then collects the result and writes zero to the control register to lock the port again. The hidden banks are modelled as small arrays, one per implemented bank. Bank 2 has no storage.

Top module: `banked_reg_port`

## Requirements
- R1: After reset, every readable register (control at 20, read data at 21, staging at 23) reads 0x0000. Every hidden word is 0x0000, and the port is locked.
- R2: `reg_rdata` presents the register addressed in the previous cycle. The control register at address 20 and the staging register at address 23 read back the last value written to them. Address 21 ignores writes. Every other address reads zero and ignores writes.
- R3: The port unlocks after four consecutive writes to address 20 with the values 0x0000, 0x0400, 0x0000, 0x0400. Writes to other addresses between them do not count as steps.
- R4: A control write that does not match the expected step while locked restarts the pattern. If that write is 0x0000, it counts as the first step of the new pattern. Otherwise tracking returns to the start.
- R5: Writing 0x0000 to address 20 while unlocked locks the port again.
- R6: While unlocked, a control word with bit 15 (read) set, bit 14 clear and bit 10 (test mode) set copies the word at bank bits 12:11, address bits 9:5 into the read-data register. Without bit 10 the word is a no-op.
- R7: While unlocked, a control word with bit 14 (write) set, bit 15 clear and bit 10 set stores the staging register into bank bits 12:11, address bits 4:0.
- R8: While locked, commands are ignored: the read-data register keeps its value and no hidden word changes.
- R9: A control word with both bit 15 and bit 14 set is a no-op for reads and writes.
- R10: Banks 0, 1 and 3 hold independent storage. Bank 2 reads as zero, and writes to it are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 5 | Register address for read and write |
| reg_we | input | 1 | Write enable for the addressed register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data of the address from the previous cycle |

## Verification
A wrong unlock step count or lock flag shows at the ports within one access. A command that should be ignored either changes address 21 on the next read, or a command that should run leaves it stale. In both cases the error is visible two cycles after the control write. A hidden word that is corrupted, aliased across banks or written to the missing bank stays invisible until a later read command names it. For that reason the tests read back every word they write, and also read neighbouring banks at the same address.

// File: rtl/brp_pkg.sv
package brp_pkg;
  localparam int DW          = 16;
  localparam int MAP_AW      = 5;
  localparam int BANK_AW     = 5;
  localparam int NUM_BANKS   = 4;
  localparam int BSEL_W      = $clog2(NUM_BANKS);

  localparam logic [MAP_AW-1:0] ADDR_CTRL  = 5'd20;
  localparam logic [MAP_AW-1:0] ADDR_RDAT  = 5'd21;
  localparam logic [MAP_AW-1:0] ADDR_STAGE = 5'd23;

  localparam int BIT_RD   = 15;
  localparam int BIT_WR   = 14;
  localparam int BSEL_HI  = 12;
  localparam int BSEL_LO  = 11;
  localparam int BIT_TM   = 10;
  localparam int RADDR_HI = 9;
  localparam int RADDR_LO = 5;
  localparam int WADDR_HI = 4;
  localparam int WADDR_LO = 0;

  localparam logic [DW-1:0] TM_ONLY = DW'(1) << BIT_TM;

  typedef struct packed {
    logic               go_rd;
    logic               go_wr;
    logic [BSEL_W-1:0]  bank;
    logic [BANK_AW-1:0] raddr;
    logic [BANK_AW-1:0] waddr;
  } cmd_t;
endpackage

// File: rtl/brp_unlock.sv
module brp_unlock
  import brp_pkg::*;
#(
  parameter int STEPS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctrl_we,
  input  logic [DW-1:0] ctrl_wdata,
  output logic          unlocked
);
  localparam int SW = $clog2(STEPS);

  logic [SW-1:0] step_q;
  logic [DW-1:0] expect_w;

  // even steps expect zero, odd steps expect test mode alone
  assign expect_w = step_q[0] ? TM_ONLY : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q   <= '0;
      unlocked <= 1'b0;
    end else if (ctrl_we) begin
      if (unlocked) begin
        if (ctrl_wdata == '0) begin
          unlocked <= 1'b0;
          step_q   <= SW'(1);
        end
      end else if (ctrl_wdata == expect_w) begin
        if (step_q == SW'(STEPS-1)) begin
          unlocked <= 1'b1;
          step_q   <= '0;
        end else begin
          step_q <= step_q + SW'(1);
        end
      end else begin
        step_q <= (ctrl_wdata == '0) ? SW'(1) : '0;
      end
    end
  end

  // R3
  unlock_after_tm_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> $past(ctrl_we && ctrl_wdata == TM_ONLY));

  // R5
  relock_on_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && ctrl_wdata == '0) |=> !unlocked);

  // R4
  stray_stays_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && !unlocked && ctrl_wdata != '0 && ctrl_wdata != TM_ONLY) |=> !unlocked);
endmodule

// File: rtl/brp_cmd_decode.sv
module brp_cmd_decode
  import brp_pkg::*;
(
  input  logic [DW-1:0] word,
  output cmd_t          cmd
);
  logic tm;
  assign tm = word[BIT_TM];

  always_comb begin
    cmd.go_rd = tm &&  word[BIT_RD] && !word[BIT_WR];
    cmd.go_wr = tm &&  word[BIT_WR] && !word[BIT_RD];
    cmd.bank  = word[BSEL_HI:BSEL_LO];
    cmd.raddr = word[RADDR_HI:RADDR_LO];
    cmd.waddr = word[WADDR_HI:WADDR_LO];
  end
endmodule

// File: rtl/brp_bank.sv
module brp_bank
  import brp_pkg::*;
#(
  parameter bit PRESENT = 1'b1,
  parameter int DEPTH   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [BANK_AW-1:0] waddr,
  input  logic [DW-1:0]      wdata,
  input  logic [BANK_AW-1:0] raddr,
  output logic [DW-1:0]      rdata
);
  generate
    if (PRESENT) begin : g_mem
      logic [DW-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
          mem[waddr] <= wdata;
        end
      end
      assign rdata = mem[raddr];
    end else begin : g_hole
      logic unused_hole;
      assign unused_hole = ^{clk, rst, we, waddr, wdata, raddr};
      assign rdata = '0;
    end
  endgenerate
endmodule

// File: rtl/banked_reg_port.sv
module banked_reg_port
  import brp_pkg::*;
#(
  parameter logic [NUM_BANKS-1:0] BANK_MASK    = 4'b1011,
  parameter int                   UNLOCK_STEPS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MAP_AW-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata
);
  localparam int DEPTH = 1 << BANK_AW;

  logic [DW-1:0] ctrl_q, stage_q, rd_q;
  logic          ctrl_we, unlocked;
  cmd_t          cmd;
  logic          exec_rd, exec_wr;
  logic [DW-1:0] bank_rdata [NUM_BANKS];

  assign ctrl_we = reg_we && (reg_addr == ADDR_CTRL);

  brp_unlock #(.STEPS(UNLOCK_STEPS)) u_unlock (
    .clk        (clk),
    .rst        (rst),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (reg_wdata),
    .unlocked   (unlocked)
  );

  brp_cmd_decode u_dec (
    .word (reg_wdata),
    .cmd  (cmd)
  );

  assign exec_rd = ctrl_we && unlocked && cmd.go_rd;
  assign exec_wr = ctrl_we && unlocked && cmd.go_wr;

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      brp_bank #(.PRESENT(BANK_MASK[b]), .DEPTH(DEPTH)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (exec_wr && (cmd.bank == BSEL_W'(b))),
        .waddr (cmd.waddr),
        .wdata (stage_q),
        .raddr (cmd.raddr),
        .rdata (bank_rdata[b])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      stage_q <= '0;
      rd_q    <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= reg_wdata;
      if (reg_we && reg_addr == ADDR_STAGE) stage_q <= reg_wdata;
      if (exec_rd) rd_q <= bank_rdata[cmd.bank];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        ADDR_CTRL:  reg_rdata <= ctrl_q;
        ADDR_RDAT:  reg_rdata <= rd_q;
        ADDR_STAGE: reg_rdata <= stage_q;
        default:    reg_rdata <= '0;
      endcase
    end
  end

  // R1
  reset_rdata_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> reg_rdata == '0);

  // R8
  locked_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && !unlocked) |=> $stable(rd_q));

  // R9
  dual_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && reg_wdata[BIT_RD] && reg_wdata[BIT_WR]) |=> $stable(rd_q));

  // R10
  hole_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && unlocked && reg_wdata[BIT_RD] && !reg_wdata[BIT_WR] &&
     reg_wdata[BIT_TM] && reg_wdata[BSEL_HI:BSEL_LO] == 2'd2) |=> rd_q == '0);

  // R2
  rdat_readonly_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == ADDR_RDAT) |=> $stable(rd_q));
endmodule

// File: tb/tb_banked_reg_port.sv
module tb_banked_reg_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  banked_reg_port dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b0;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic open_port();
    wr(20, 16'h0000); wr(20, 16'h0400); wr(20, 16'h0000); wr(20, 16'h0400);
  endtask

  function automatic logic [15:0] rcmd(input int b, input int a);
    return 16'h8400 | 16'(b << 11) | 16'(a << 5);
  endfunction

  function automatic logic [15:0] wcmd(input int b, input int a);
    return 16'h4400 | 16'(b << 11) | 16'(a);
  endfunction

  task automatic bank_wr(input int b, input int a, input logic [15:0] v);
    open_port();
    wr(23, v);
    wr(20, wcmd(b, a));
    wr(20, 16'h0000);
  endtask

  task automatic bank_rd(input int b, input int a, output logic [15:0] v);
    open_port();
    wr(20, rcmd(b, a));
    rd(21, v);
    wr(20, 16'h0000);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(20, v); chk("R1 ctrl", v, 16'h0);
    rd(21, v); chk("R1 rdat", v, 16'h0);
    rd(23, v); chk("R1 stage", v, 16'h0);
    bank_rd(3, 5'h1b, v); chk("R1 hidden word", v, 16'h0);
  endtask

  task automatic t_map();
    logic [15:0] v;
    wr(23, 16'hbeef); rd(23, v); chk("R2 stage readback", v, 16'hbeef);
    wr(20, 16'h1234); rd(20, v); chk("R2 ctrl readback", v, 16'h1234);
    wr(21, 16'h5555); rd(21, v); chk("R2 rdat readonly", v, 16'h0);
    wr(5, 16'h7777);  rd(5, v);  chk("R2 other addr zero", v, 16'h0);
    wr(20, 16'h0000);
  endtask

  task automatic t_banks();
    logic [15:0] v;
    bank_wr(3, 5'h1b, 16'h0005);
    bank_wr(3, 5'h1d, 16'h029a);
    bank_wr(3, 5'h1c, 16'haaaa);
    bank_wr(1, 5'h0c, 16'h1000);
    bank_wr(0, 5'h1b, 16'h00f0);
    bank_wr(0, 0, 16'hc001);
    bank_wr(1, 31, 16'h8001);
    bank_rd(3, 5'h1b, v); chk("R7 bank3 1b", v, 16'h0005);
    bank_rd(3, 5'h1c, v); chk("R6 bank3 1c", v, 16'haaaa);
    bank_rd(3, 5'h1d, v); chk("R6 bank3 1d", v, 16'h029a);
    bank_rd(1, 5'h0c, v); chk("R6 bank1 0c", v, 16'h1000);
    bank_rd(0, 5'h1b, v); chk("R10 bank0 separate", v, 16'h00f0);
    bank_rd(1, 5'h1b, v); chk("R10 bank1 separate", v, 16'h0000);
    bank_rd(0, 0, v);     chk("R7 addr 0", v, 16'hc001);
    bank_rd(1, 31, v);    chk("R7 addr 31", v, 16'h8001);
  endtask

  task automatic t_hole();
    logic [15:0] v;
    bank_rd(3, 5'h1c, v);
    bank_wr(2, 5'h1c, 16'h4242);
    bank_rd(2, 5'h1c, v); chk("R10 bank2 reads zero", v, 16'h0);
    bank_rd(3, 5'h1c, v); chk("R10 bank2 write discarded", v, 16'haaaa);
  endtask

  task automatic t_locked();
    logic [15:0] v;
    bank_rd(3, 5'h1d, v);
    wr(20, rcmd(3, 5'h1c));
    rd(21, v); chk("R8 locked read ignored", v, 16'h029a);
    wr(23, 16'h0bad);
    wr(20, wcmd(3, 5'h1d));
    bank_rd(3, 5'h1d, v); chk("R8 locked write ignored", v, 16'h029a);
  endtask

  task automatic t_pattern();
    logic [15:0] v;
    bank_rd(1, 5'h0c, v);
    wr(20, 16'h0000); wr(20, 16'h0400); wr(20, 16'h0001); wr(20, 16'h0400);
    wr(20, rcmd(3, 5'h1c));
    rd(21, v); chk("R4 broken pattern locked", v, 16'h1000);
    wr(20, 16'h0000); wr(20, 16'h0400); wr(20, 16'h0400);
    wr(20, 16'h0000); wr(20, 16'h0400);
    wr(20, rcmd(3, 5'h1c));
    rd(21, v); chk("R4 stray tm restarts", v, 16'h1000);
    wr(20, 16'h0000); wr(20, 16'h0400); wr(20, 16'h0000); wr(20, 16'h0000);
    wr(20, 16'h0400); wr(20, 16'h0000); wr(20, 16'h0400);
    wr(20, rcmd(3, 5'h1c));
    rd(21, v); chk("R4 zero counts as first step", v, 16'haaaa);
    wr(20, 16'h0000);
    wr(20, 16'h0000); wr(23, 16'h1111); wr(20, 16'h0400); rd(7, v);
    wr(20, 16'h0000); wr(20, 16'h0400);
    wr(20, rcmd(3, 5'h1d));
    rd(21, v); chk("R3 other writes between steps", v, 16'h029a);
    wr(20, 16'h0000);
  endtask

  task automatic t_relock();
    logic [15:0] v;
    open_port();
    wr(20, rcmd(1, 5'h0c));
    rd(21, v); chk("R6 open read", v, 16'h1000);
    wr(20, 16'h0000);
    wr(20, rcmd(3, 5'h1b));
    rd(21, v); chk("R5 relocked", v, 16'h1000);
  endtask

  task automatic t_dual_and_tm();
    logic [15:0] v;
    open_port();
    wr(20, rcmd(3, 5'h1b));
    rd(21, v); chk("R6 setup", v, 16'h0005);
    wr(20, rcmd(3, 5'h1c) | 16'h4000);
    rd(21, v); chk("R9 dual strobe no read", v, 16'h0005);
    wr(23, 16'hdead);
    wr(20, wcmd(3, 5'h1b) | 16'h8000);
    wr(20, rcmd(3, 5'h1d) & 16'hfbff);
    rd(21, v); chk("R6 missing test mode", v, 16'h0005);
    wr(20, rcmd(3, 5'h1b));
    rd(21, v); chk("R9 dual strobe no write", v, 16'h0005);
    wr(20, 16'h0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_map();
    t_banks();
    t_hole();
    t_locked();
    t_pattern();
    t_relock();
    t_dual_and_tm();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule